// File: doc/BRIEF.md
# Transactional Checkpoint and Rollback Buffer

This block sits next to the private data cache of one core that runs hardware transactions with lazy version management. Speculative stores never reach shared memory before commit; instead the block holds them as ordered versions per cache line. Each time a transaction touches a line it has not touched before, the block records the core's register context in a small ring of checkpoints. The capture uses the same cycle as the access, so it hides behind the cache miss that a first access causes and costs no stall.

When the coherence logic reports a conflict on a line, the block looks up the checkpoint recorded just before that line was first touched. It hands that context back to the core for a partial restart. It then discards every later checkpoint and every speculative version written after that point, so each line falls back to its newest surviving version. A commit pulse clears the checkpoints and turns the surviving versions into committed data. An access presented in the same cycle as a conflict or a commit is dropped.

Top module: `tcb_top`

## Requirements
- R1: After reset, `rst_valid` is low and a lookup of any line reports `lk_hit` low.
- R2: The first access to a line not yet seen in the transaction captures `ctx_in` as checkpoint number N, where N counts the checkpoints already held (0 for the first). A repeated access to a known line captures nothing.
- R3: A conflict on a tracked line raises `rst_valid` for exactly one cycle, on the clock edge after the cycle in which `conf_valid` was sampled. In that cycle `rst_ctx` and `rst_seq` give the context and number of the checkpoint taken before that line's first access.
- R4: A conflict on a line the transaction never accessed has no effect: no restore pulse, and buffered line data stays unchanged.
- R5: A rollback to checkpoint k discards checkpoints k and above, so the next new line receives checkpoint number k.
- R6: A store is buffered as a speculative version, and `lk_spec`=1 on lookup. A second store to the same line within one checkpoint interval overwrites that version and keeps its `lk_order`. A store in a later interval creates a new version with a larger `lk_order`. Lookup returns the newest version.
- R7: After a rollback to k, every version written at or after checkpoint k is discarded. A line reverts to its newest surviving version, or misses if none survives.
- R8: With all NCKPT (default 8) checkpoints in use, a new line takes no checkpoint. A conflict on such a line restores checkpoint 0, the start of the transaction.
- R9: A commit clears all checkpoints, so the next new line receives checkpoint 0. Surviving versions become committed (`lk_spec`=0) and are kept across later rollbacks.
- R10: When `conf_valid` and `commit` are high in the same cycle, the conflict is served and the commit is ignored; the remaining versions stay speculative.
- R11: When the line table (NLINES, default 16) is full, further new lines are untracked. A conflict on an untracked line restores checkpoint 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Cache access by the transaction this cycle |
| acc_line | input | LINE_W | Line address of the access |
| acc_write | input | 1 | Access is a store |
| acc_wdata | input | DATA_W | Store data for the line |
| ctx_in | input | CTX_W | Current core register context |
| conf_valid | input | 1 | Conflict reported this cycle |
| conf_line | input | LINE_W | Line address of the conflict |
| commit | input | 1 | Transaction commit pulse |
| lk_line | input | LINE_W | Line address to look up |
| lk_hit | output | 1 | A version exists for `lk_line` |
| lk_spec | output | 1 | Returned version is speculative |
| lk_order | output | ORD_W | Modification-order id of the returned version |
| lk_data | output | DATA_W | Data of the returned version |
| rst_valid | output | 1 | One-cycle restore strobe |
| rst_seq | output | $clog2(NCKPT) | Checkpoint number being restored |
| rst_ctx | output | CTX_W | Context to restore |

## Verification
The bench rolls back to a middle checkpoint and then checks three things. A line first touched later must miss, or an over-eager design would leave stale data visible. A line written both before and after the checkpoint must fall back to the older value, which a design that drops whole lines would lose. The next new line must reuse the freed number, which a design that never rewinds its count would not. It fills the checkpoint ring and the line table so that a conflict on an uncovered line must return to checkpoint 0, where a faulty design would pick a wrong or stale context. It also issues a commit and a conflict together, where getting the priority wrong would commit data and then restore a checkpoint that no longer exists.

// File: rtl/tcb_pkg.sv
// Shared types for the transactional checkpoint buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package tcb_pkg;

    // Kind of rollback a conflict resolves to
    typedef enum logic [1:0] {
        RB_NONE     = 2'd0,
        RB_TO_LINE  = 2'd1,
        RB_TO_START = 2'd2
    } rb_kind_e;

endpackage

// File: rtl/tcb_ckpt_ring.sv
// Checkpoint ring: holds up to NCKPT register-context snapshots numbered in
// capture order. A rollback to k truncates the count to k; clear empties it.
// Assumes: take is never asserted together with rb or clear.
module tcb_ckpt_ring #(
    parameter int NCKPT = 8,
    parameter int CTX_W = 64,
    localparam int SEQ_W = (NCKPT > 1) ? $clog2(NCKPT) : 1,
    localparam int CNT_W = $clog2(NCKPT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CTX_W-1:0] ctx_in,
    input  logic             clear,
    input  logic             rb,
    input  logic [SEQ_W-1:0] rb_seq,
    output logic [CTX_W-1:0] rd_ctx,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    logic [CTX_W-1:0] ctx_q [NCKPT];
    logic [CNT_W-1:0] cnt_q;

    assign cnt    = cnt_q;
    assign full   = (cnt_q == CNT_W'(NCKPT));
    assign rd_ctx = ctx_q[rb_seq];

    // Checkpoint count: rewind on rollback, empty on clear, grow on capture
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (rb)         cnt_q <= CNT_W'(rb_seq);
        else if (clear)      cnt_q <= '0;
        else if (take && !full) cnt_q <= cnt_q + CNT_W'(1);
    end

    // Snapshot storage, written at the slot named by the current count
    always_ff @(posedge clk) begin
        if (take && !full) ctx_q[cnt_q[SEQ_W-1:0]] <= ctx_in;
    end

    AST_TAKE_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !full); // R8
    AST_RB_EXISTING: assert property (@(posedge clk) disable iff (!rst_n)
        rb |-> (CNT_W'(rb_seq) < cnt_q)); // R5

endmodule

// File: rtl/tcb_line_table.sv
// Line table: remembers each line the transaction touched and the number of
// the checkpoint taken just before its first access (if one was taken).
// Answers whether an access is a first access and where a conflict rolls to.
// Assumes: acc_en, rb and clear are mutually exclusive in a cycle.
module tcb_line_table #(
    parameter int NLINES = 16,
    parameter int LINE_W = 26,
    parameter int SEQ_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              ck_take,
    input  logic [SEQ_W-1:0]  ck_seq,
    input  logic              rb,
    input  logic [SEQ_W-1:0]  rb_seq,
    input  logic              clear,
    input  logic [LINE_W-1:0] conf_line,
    output logic              acc_hit,
    output logic              room,
    output logic              conf_hit,
    output logic              conf_has,
    output logic [SEQ_W-1:0]  conf_seq,
    output logic              ovf
);

    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;

    logic              vld_q  [NLINES];
    logic              has_q  [NLINES];
    logic [SEQ_W-1:0]  seq_q  [NLINES];
    logic [LINE_W-1:0] line_q [NLINES];
    logic              ovf_q;
    logic [NLINES-1:0] acc_match;
    logic [NLINES-1:0] conf_match;
    logic [IDX_W-1:0]  free_idx;

    // Per-entry address comparators for the access and conflict ports
    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign acc_match[g]  = vld_q[g] && (line_q[g] == acc_line);
        assign conf_match[g] = vld_q[g] && (line_q[g] == conf_line);
    end

    assign acc_hit = |acc_match;
    assign ovf     = ovf_q;

    // Lowest free entry for allocation
    always_comb begin
        room     = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (!vld_q[i] && !room) begin
                room     = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Conflict lookup: first-access checkpoint of the conflicting line
    always_comb begin
        conf_hit = 1'b0;
        conf_has = 1'b0;
        conf_seq = '0;
        for (int i = 0; i < NLINES; i++) begin
            if (conf_match[i]) begin
                conf_hit = 1'b1;
                conf_has = has_q[i];
                conf_seq = seq_q[i];
            end
        end
    end

    // Entry state: drop later lines on rollback, empty on commit, allocate on first access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) vld_q[i] <= 1'b0;
            ovf_q <= 1'b0;
        end else if (rb) begin
            for (int i = 0; i < NLINES; i++)
                if (vld_q[i] && (!has_q[i] || seq_q[i] >= rb_seq)) vld_q[i] <= 1'b0;
            ovf_q <= 1'b0;
        end else if (clear) begin
            for (int i = 0; i < NLINES; i++) vld_q[i] <= 1'b0;
            ovf_q <= 1'b0;
        end else if (acc_en && !acc_hit) begin
            if (room) begin
                vld_q[free_idx]  <= 1'b1;
                line_q[free_idx] <= acc_line;
                has_q[free_idx]  <= ck_take;
                seq_q[free_idx]  <= ck_seq;
            end else begin
                ovf_q <= 1'b1;
            end
        end
    end

    AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> $onehot0(acc_match)); // R2
    AST_TAKE_ONLY_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        ck_take |-> (acc_en && !acc_hit)); // R2

endmodule

// File: rtl/tcb_ver_store.sv
// Version store: speculative line versions, one per line per checkpoint
// interval, each tagged with a modification-order id. Rollback drops versions
// of later intervals; commit keeps only the newest version of each line.
// Assumes: NVER is large enough for the transaction; a store with no free
// entry is dropped. wr_en, rb and commit are mutually exclusive.
module tcb_ver_store #(
    parameter int NVER   = 16,
    parameter int LINE_W = 26,
    parameter int DATA_W = 32,
    parameter int SEQ_W  = 3,
    parameter int ORD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic              rb,
    input  logic [SEQ_W-1:0]  rb_seq,
    input  logic              commit,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic              lk_spec,
    output logic [ORD_W-1:0]  lk_order,
    output logic [DATA_W-1:0] lk_data
);

    localparam int IDX_W = (NVER > 1) ? $clog2(NVER) : 1;

    logic              vld_q  [NVER];
    logic              spec_q [NVER];
    logic [LINE_W-1:0] line_q [NVER];
    logic [SEQ_W-1:0]  seq_q  [NVER];
    logic [ORD_W-1:0]  ord_q  [NVER];
    logic [DATA_W-1:0] data_q [NVER];
    logic [ORD_W-1:0]  ord_cnt_q;
    logic [NVER-1:0]   upd_oh, alloc_oh, sup, spec_vec;
    logic [NVER-1:0]   same_iv;
    logic [IDX_W-1:0]  sel;
    logic [SEQ_W:0]    best;

    // Per-entry match against the current store's line and interval
    for (genvar g = 0; g < NVER; g++) begin : g_iv
        assign same_iv[g]  = vld_q[g] && spec_q[g] && (line_q[g] == wr_line)
                             && (seq_q[g] == wr_seq);
        assign spec_vec[g] = vld_q[g] && spec_q[g];
    end

    // Choose in-place update or allocation of the lowest free entry
    always_comb begin
        upd_oh   = '0;
        alloc_oh = '0;
        if (|same_iv) begin
            for (int i = 0; i < NVER; i++)
                if (same_iv[i] && upd_oh == '0) upd_oh[i] = 1'b1;
        end else begin
            for (int i = 0; i < NVER; i++)
                if (!vld_q[i] && alloc_oh == '0) alloc_oh[i] = 1'b1;
        end
    end

    // Entries superseded by a newer speculative version of the same line
    always_comb begin
        sup = '0;
        for (int i = 0; i < NVER; i++)
            for (int j = 0; j < NVER; j++)
                if (j != i && vld_q[j] && spec_q[j] && line_q[j] == line_q[i]
                    && (!spec_q[i] || seq_q[j] > seq_q[i]))
                    sup[i] = 1'b1;
    end

    // Lookup: newest version, speculative by interval first, else committed
    always_comb begin
        lk_hit = 1'b0;
        best   = '0;
        sel    = '0;
        for (int i = 0; i < NVER; i++) begin
            if (vld_q[i] && line_q[i] == lk_line
                && (!lk_hit || {spec_q[i], seq_q[i]} > best)) begin
                lk_hit = 1'b1;
                best   = {spec_q[i], seq_q[i]};
                sel    = IDX_W'(i);
            end
        end
        lk_spec  = lk_hit && spec_q[sel];
        lk_order = ord_q[sel];
        lk_data  = data_q[sel];
    end

    // Version entries: rollback trim, commit collapse, store update/allocate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVER; i++) vld_q[i] <= 1'b0;
            ord_cnt_q <= '0;
        end else if (rb) begin
            for (int i = 0; i < NVER; i++)
                if (vld_q[i] && spec_q[i] && seq_q[i] >= rb_seq) vld_q[i] <= 1'b0;
        end else if (commit) begin
            for (int i = 0; i < NVER; i++) begin
                if (sup[i]) vld_q[i]  <= 1'b0;
                else        spec_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NVER; i++) begin
                if (upd_oh[i]) data_q[i] <= wr_data;
                if (alloc_oh[i]) begin
                    vld_q[i]  <= 1'b1;
                    spec_q[i] <= 1'b1;
                    line_q[i] <= wr_line;
                    seq_q[i]  <= wr_seq;
                    ord_q[i]  <= ord_cnt_q;
                    data_q[i] <= wr_data;
                end
            end
            if (alloc_oh != '0) ord_cnt_q <= ord_cnt_q + ORD_W'(1);
        end
    end

    AST_ONE_WRITE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $onehot0(upd_oh | alloc_oh)); // R6
    AST_COMMIT_CLEARS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rb && !wr_en) |=> (spec_vec == '0)); // R9

endmodule

// File: rtl/tcb_top.sv
// Transactional checkpoint and rollback buffer. Ties the checkpoint ring,
// line table and version store together, resolves conflicts to a rollback
// point and drives a one-cycle registered restore strobe.
// Assumes: lines are addressed at line granularity; conflict beats commit,
// and both block any access presented in the same cycle.
module tcb_top
    import tcb_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int DATA_W = 32,
    parameter int CTX_W  = 64,
    parameter int NCKPT  = 8,
    parameter int NLINES = 16,
    parameter int NVER   = 16,
    parameter int ORD_W  = 8,
    localparam int SEQ_W = (NCKPT > 1) ? $clog2(NCKPT) : 1,
    localparam int CNT_W = $clog2(NCKPT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [CTX_W-1:0]  ctx_in,
    input  logic              conf_valid,
    input  logic [LINE_W-1:0] conf_line,
    input  logic              commit,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic              lk_spec,
    output logic [ORD_W-1:0]  lk_order,
    output logic [DATA_W-1:0] lk_data,
    output logic              rst_valid,
    output logic [SEQ_W-1:0]  rst_seq,
    output logic [CTX_W-1:0]  rst_ctx
);

    logic             acc_en, acc_hit, room, take, full, ovf;
    logic             conf_hit, conf_has, rb_fire, commit_en;
    logic [SEQ_W-1:0] conf_seq, rb_seq, wr_seq;
    logic [CNT_W-1:0] cnt, cnt_m1;
    logic [CTX_W-1:0] rd_ctx;
    rb_kind_e         rb_kind;

    logic             rst_valid_q;
    logic [SEQ_W-1:0] rst_seq_q;
    logic [CTX_W-1:0] rst_ctx_q;

    assign acc_en    = acc_valid && !conf_valid && !commit;
    assign commit_en = commit && !conf_valid;
    assign take      = acc_en && !acc_hit && room && !full;

    // Interval of a store: the fresh checkpoint, else the newest held one
    always_comb begin
        cnt_m1 = cnt - CNT_W'(1);
        if (take)           wr_seq = cnt[SEQ_W-1:0];
        else if (cnt == '0) wr_seq = '0;
        else                wr_seq = cnt_m1[SEQ_W-1:0];
    end

    // Conflict resolution to a rollback checkpoint
    always_comb begin
        rb_kind = RB_NONE;
        if (conf_valid && cnt != '0) begin
            if (conf_hit && conf_has)  rb_kind = RB_TO_LINE;
            else if (conf_hit || ovf)  rb_kind = RB_TO_START;
        end
        rb_fire = (rb_kind != RB_NONE);
        rb_seq  = (rb_kind == RB_TO_LINE) ? conf_seq : '0;
    end

    tcb_ckpt_ring #(.NCKPT(NCKPT), .CTX_W(CTX_W)) ring_i (
        .clk(clk), .rst_n(rst_n), .take(take), .ctx_in(ctx_in),
        .clear(commit_en), .rb(rb_fire), .rb_seq(rb_seq),
        .rd_ctx(rd_ctx), .cnt(cnt), .full(full)
    );

    tcb_line_table #(.NLINES(NLINES), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) lines_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_line(acc_line),
        .ck_take(take), .ck_seq(cnt[SEQ_W-1:0]), .rb(rb_fire), .rb_seq(rb_seq),
        .clear(commit_en), .conf_line(conf_line), .acc_hit(acc_hit),
        .room(room), .conf_hit(conf_hit), .conf_has(conf_has),
        .conf_seq(conf_seq), .ovf(ovf)
    );

    tcb_ver_store #(.NVER(NVER), .LINE_W(LINE_W), .DATA_W(DATA_W),
                    .SEQ_W(SEQ_W), .ORD_W(ORD_W)) vers_i (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_en && acc_write),
        .wr_line(acc_line), .wr_data(acc_wdata), .wr_seq(wr_seq),
        .rb(rb_fire), .rb_seq(rb_seq), .commit(commit_en), .lk_line(lk_line),
        .lk_hit(lk_hit), .lk_spec(lk_spec), .lk_order(lk_order), .lk_data(lk_data)
    );

    // Registered restore strobe with the selected checkpoint
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_valid_q <= 1'b0;
            rst_seq_q   <= '0;
            rst_ctx_q   <= '0;
        end else begin
            rst_valid_q <= rb_fire;
            if (rb_fire) begin
                rst_seq_q <= rb_seq;
                rst_ctx_q <= rd_ctx;
            end
        end
    end

    assign rst_valid = rst_valid_q;
    assign rst_seq   = rst_seq_q;
    assign rst_ctx   = rst_ctx_q;

    AST_RESTORE_AFTER_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |-> $past(conf_valid)); // R3
    AST_UNTOUCHED_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_valid && !conf_hit && !ovf) |=> !rst_valid); // R4

endmodule

// File: tb/tcb_top_tb.sv
// Directed bench for tcb_top; one task per scenario, each checking itself.
module tcb_top_tb_top;

    localparam int LINE_W = 26;
    localparam int DATA_W = 32;
    localparam int CTX_W  = 64;
    localparam int ORD_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic [LINE_W-1:0] acc_line = '0;
    logic              acc_write = 1'b0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic [CTX_W-1:0]  ctx_in = '0;
    logic              conf_valid = 1'b0;
    logic [LINE_W-1:0] conf_line = '0;
    logic              commit = 1'b0;
    logic [LINE_W-1:0] lk_line = '0;
    logic              lk_hit, lk_spec, rst_valid;
    logic [ORD_W-1:0]  lk_order;
    logic [DATA_W-1:0] lk_data;
    logic [2:0]        rst_seq;
    logic [CTX_W-1:0]  rst_ctx;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk; // 125 MHz

    tcb_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_write(acc_write), .acc_wdata(acc_wdata), .ctx_in(ctx_in),
        .conf_valid(conf_valid), .conf_line(conf_line), .commit(commit),
        .lk_line(lk_line), .lk_hit(lk_hit), .lk_spec(lk_spec),
        .lk_order(lk_order), .lk_data(lk_data), .rst_valid(rst_valid),
        .rst_seq(rst_seq), .rst_ctx(rst_ctx)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [LINE_W-1:0] line, input bit we,
                       input logic [DATA_W-1:0] d, input logic [CTX_W-1:0] c);
        @(negedge clk);
        acc_valid = 1'b1; acc_line = line; acc_write = we;
        acc_wdata = d; ctx_in = c;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk); commit = 1'b1;
        @(negedge clk); commit = 1'b0;
    endtask

    // Conflict with optional simultaneous commit; checks strobe and its width
    task automatic conflict(input logic [LINE_W-1:0] line, input bit with_commit,
                            input bit exp_v, input logic [2:0] exp_seq,
                            input logic [CTX_W-1:0] exp_ctx, input string req);
        @(negedge clk);
        conf_valid = 1'b1; conf_line = line; commit = with_commit;
        @(negedge clk);
        conf_valid = 1'b0; commit = 1'b0;
        check(rst_valid == exp_v, {req, " strobe"}, 64'(rst_valid), 64'(exp_v));
        if (exp_v) begin
            check(rst_seq == exp_seq, {req, " seq"}, 64'(rst_seq), 64'(exp_seq));
            check(rst_ctx == exp_ctx, {req, " ctx"}, rst_ctx, exp_ctx);
            @(negedge clk);
            check(rst_valid == 1'b0, "R3 single-cycle strobe", 64'(rst_valid), 64'd0);
        end
    endtask

    task automatic look(input logic [LINE_W-1:0] line, input bit exp_hit,
                        input bit exp_spec, input logic [DATA_W-1:0] exp_d,
                        input string req);
        lk_line = line;
        #1;
        check(lk_hit == exp_hit, {req, " hit"}, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            check(lk_spec == exp_spec, {req, " spec"}, 64'(lk_spec), 64'(exp_spec));
            check(lk_data == exp_d, {req, " data"}, 64'(lk_data), 64'(exp_d));
        end
    endtask

    task automatic t_reset();
        check(rst_valid == 1'b0, "R1 no strobe after reset", 64'(rst_valid), 64'd0);
        look(26'h0A, 1'b0, 1'b0, '0, "R1 empty store");
    endtask

    // Partial rollback, version ordering, unknown-line conflict, commit
    task automatic t_basic();
        logic [ORD_W-1:0] o1;
        acc(26'h0A, 1'b1, 32'd11, 64'h100);            // checkpoint 0
        look(26'h0A, 1'b1, 1'b1, 32'd11, "R6 buffered store");
        o1 = lk_order;
        acc(26'h0A, 1'b1, 32'd12, 64'h111);            // same interval
        look(26'h0A, 1'b1, 1'b1, 32'd12, "R6 same-interval overwrite");
        check(lk_order == o1, "R6 order kept", 64'(lk_order), 64'(o1));
        acc(26'h0B, 1'b1, 32'd22, 64'h200);            // checkpoint 1
        acc(26'h0A, 1'b1, 32'd33, 64'h300);            // interval 1
        look(26'h0A, 1'b1, 1'b1, 32'd33, "R6 newest version");
        check(lk_order > o1, "R6 later order", 64'(lk_order), 64'(o1) + 1);
        acc(26'h0C, 1'b0, 32'd0, 64'h400);             // checkpoint 2
        conflict(26'h0B, 1'b0, 1'b1, 3'd1, 64'h200, "R3 restore to B");
        look(26'h0A, 1'b1, 1'b1, 32'd12, "R7 revert to older version");
        look(26'h0B, 1'b0, 1'b0, '0, "R7 later line dropped");
        conflict(26'h0E, 1'b0, 1'b0, 3'd0, '0, "R4 unknown line");
        look(26'h0A, 1'b1, 1'b1, 32'd12, "R4 data unchanged");
        conflict(26'h0C, 1'b0, 1'b0, 3'd0, '0, "R5 discarded line not tracked");
        acc(26'h0D, 1'b0, 32'd0, 64'h500);
        conflict(26'h0D, 1'b0, 1'b1, 3'd1, 64'h500, "R5 reused number");
        do_commit();
        look(26'h0A, 1'b1, 1'b0, 32'd12, "R9 committed version");
        acc(26'h0F, 1'b0, 32'd0, 64'h600);
        conflict(26'h0F, 1'b0, 1'b1, 3'd0, 64'h600, "R9 numbering restarts");
        acc(26'h0A, 1'b1, 32'd44, 64'h700);
        look(26'h0A, 1'b1, 1'b1, 32'd44, "R9 new speculative over committed");
        conflict(26'h0A, 1'b0, 1'b1, 3'd0, 64'h700, "R2 first access checkpoint");
        look(26'h0A, 1'b1, 1'b0, 32'd12, "R9 committed survives rollback");
    endtask

    task automatic t_collide();
        do_commit();
        acc(26'h20, 1'b1, 32'd55, 64'h800);
        acc(26'h21, 1'b1, 32'd66, 64'h900);
        conflict(26'h21, 1'b1, 1'b1, 3'd1, 64'h900, "R10 conflict wins");
        look(26'h20, 1'b1, 1'b1, 32'd55, "R10 commit ignored");
        look(26'h21, 1'b0, 1'b0, '0, "R10 rolled back line");
    endtask

    task automatic t_full();
        do_commit();
        for (int i = 0; i < 9; i++)
            acc(26'h100 + LINE_W'(i), 1'b0, '0, 64'd1000 + 64'(i));
        conflict(26'h105, 1'b0, 1'b1, 3'd5, 64'd1005, "R2 sixth checkpoint");
        for (int i = 5; i < 9; i++)
            acc(26'h100 + LINE_W'(i), 1'b0, '0, 64'd2000 + 64'(i));
        conflict(26'h107, 1'b0, 1'b1, 3'd7, 64'd2007, "R2 last checkpoint");
        acc(26'h107, 1'b0, '0, 64'd3007);
        acc(26'h108, 1'b0, '0, 64'd3008);             // ring full
        conflict(26'h108, 1'b0, 1'b1, 3'd0, 64'd1000, "R8 full ring to start");
    endtask

    task automatic t_overflow();
        do_commit();
        for (int i = 0; i < 17; i++)
            acc(26'h200 + LINE_W'(i), 1'b0, '0, 64'd4000 + 64'(i));
        conflict(26'h210, 1'b0, 1'b1, 3'd0, 64'd4000, "R11 untracked line to start");
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_collide();
        t_full();
        t_overflow();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule